// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words whose width is a parameter (4 or 5 bits). Words are written with a shift-in strobe and read with a shift-out strobe. Two flags guard the strobes. `in_rdy` shows that there is room for a word. `out_rdy` shows that the output carries a valid word. A word written into an empty buffer reaches the output by itself after a fixed bubble delay, with no read needed. A read removes the word on the output and presents the next oldest word.

The strobes are sampled on every rising clock edge, so the flags work as a valid/ready handshake. Two instances chain end to end with no added logic:
- the sender's `out_rdy` drives the receiver's `shin`;
- the receiver's `in_rdy` drives the sender's `shout`;
- the sender's `dout` drives the receiver's `din`.

Instances placed side by side give wider words when their flags are ANDed. A synchronous active-low reset empties the buffer. An output-enable input floats the data output without touching the flags.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds `DEPTH` (default 64) words of `WIDTH` bits. `in_rdy` is low exactly when `DEPTH` words are stored, and high otherwise.
- R2: A word on `din` is stored at a rising edge where `shin` and `in_rdy` are both high.
- R3: Words leave in the order they were written. While `out_rdy` is high and `oe` is high, `dout` carries the oldest stored word.
- R4: At a rising edge where `shout` and `out_rdy` are both high, the word on `dout` is removed and the next stored word is presented.
- R5: `out_rdy` is high only while at least one stored word has completed its bubble delay, and it is low when the buffer is empty.
- R6: A word accepted at rising edge n into an empty buffer makes `out_rdy` high just after edge n+`LAT`-1 and not before. `LAT` is a parameter, default 2, so `out_rdy` is high from the edge that follows the write.
- R7: `shin` while `in_rdy` is low is ignored: the stored words and their order are unchanged.
- R8: `shout` while `out_rdy` is low is ignored: the stored word count and the read position are unchanged.
- R9: When a write and a read are both accepted at the same edge at a level between empty and full, the stored count is unchanged. At 63 words, `in_rdy` stays high.
- R10: While `rst_n` is low at a rising edge, the buffer is emptied. After that edge `out_rdy` is low and `in_rdy` is high.
- R11: While `oe` is low, `dout` is high impedance, and `in_rdy` and `out_rdy` are unaffected.
- R12: Two instances chained with the flag wiring described above form one deeper buffer that keeps word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that empties the buffer |
| oe | input | 1 | High drives `dout`; low sets it to high impedance |
| shin | input | 1 | Shift-in strobe, sampled every rising edge |
| din | input | WIDTH | Word to be written |
| in_rdy | output | 1 | High while a word can be accepted |
| shout | input | 1 | Shift-out strobe, sampled every rising edge |
| dout | output | WIDTH | Oldest visible word (tri-state) |
| out_rdy | output | 1 | High while `dout` carries a valid word |

## Verification
A write and a read can be accepted at the same edge. The interesting cases are where that meets a fill boundary or a word that is still in its bubble delay. The random phase drives both strobes together at many fill levels, with the level swept between near-empty and near-full. A directed case raises both strobes at 63 words, and another writes into an empty buffer while `shout` is held high. The bench model computes the expected flags and the expected oldest word from the requirements alone, and judges every cycle against them, including whether the pop used the old visible count.

// File: rtl/strobe_fifo_pkg.sv
// Package: shared defaults and helper functions for the strobe FIFO.
// Assumes: depths are at least 2 and latencies at least 1.
package strobe_fifo_pkg;
    localparam int unsigned FIFO_DEPTH_DEF = 64;
    localparam int unsigned FIFO_WIDTH_DEF = 4;
    localparam int unsigned FIFO_LAT_DEF   = 2;

    // Width of a counter that must reach the value n inclusive.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Width of an index into n slots.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sf_store.sv
// Module: sf_store
// Word storage with write and read pointers that wrap at DEPTH.
// Assumes: the controller never asserts wr_en when full or rd_en when empty.
module sf_store
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned WIDTH = FIFO_WIDTH_DEF,
    parameter int unsigned DEPTH = FIFO_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rd_word
);
    localparam int unsigned AW = idx_bits(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Step a pointer forward, wrapping after the last slot.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    // Store the incoming word in the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the pointers on accepted transfers; reset empties them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    // Present the oldest word to the output stage.
    assign rd_word = mem[rd_ptr];

    // R4
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_ptr != $past(rd_ptr));
    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_ptr));
endmodule

// File: rtl/sf_flags.sv
// Module: sf_flags
// Keeps the stored-word count and the visible-word count, delays each
// write by the bubble latency before it counts as visible, and forms the
// ready flags and the accepted transfer strobes.
// Assumes: LAT >= 1; all visible words are older than pending ones.
module sf_flags
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH_DEF,
    parameter int unsigned LAT   = FIFO_LAT_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shin,
    input  logic shout,
    output logic in_rdy,
    output logic out_rdy,
    output logic wr_en,
    output logic rd_en
);
    localparam int unsigned CW = cnt_bits(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] count;
    logic [CW-1:0] vis;
    logic          vis_inc;

    // Accept only strobes that the flags allow.
    assign in_rdy  = (count != FULL);
    assign out_rdy = (vis != '0);
    assign wr_en   = shin & in_rdy;
    assign rd_en   = shout & out_rdy;

    generate
        if (LAT <= 1) begin : g_direct
            // A write becomes visible at the edge that accepts it.
            assign vis_inc = wr_en;
        end else begin : g_delay
            localparam int unsigned PW = LAT - 1;
            logic [PW-1:0] pend;
            // Carry each accepted write through the bubble delay line.
            always_ff @(posedge clk) begin
                if (!rst_n) pend <= '0;
                else        pend <= (pend << 1) | PW'(wr_en);
            end
            assign vis_inc = pend[PW-1];
        end
    endgenerate

    // Track the stored and visible word counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            vis   <= '0;
        end else begin
            count <= count + CW'(wr_en) - CW'(rd_en);
            vis   <= vis + CW'(vis_inc) - CW'(rd_en);
        end
    end

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
    // R5
    vis_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vis <= count);
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rdy && shin && !shout) |=> $stable(count));
    // R8
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && shout && !shin) |=> $stable(count));
    // R9
    both_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shin && shout && in_rdy && out_rdy) |=> $stable(count));
endmodule

// File: rtl/strobe_fifo.sv
// Module: strobe_fifo (top)
// Fall-through FIFO with shift-in/shift-out strobes and ready flags that
// also serve as cascade handshakes. The output can be tri-stated.
// Assumes: strobes are synchronous to clk and sampled at each rising edge.
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned WIDTH = FIFO_WIDTH_DEF,
    parameter int unsigned DEPTH = FIFO_DEPTH_DEF,
    parameter int unsigned LAT   = FIFO_LAT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe,
    input  logic             shin,
    input  logic [WIDTH-1:0] din,
    output logic             in_rdy,
    input  logic             shout,
    output logic [WIDTH-1:0] dout,
    output logic             out_rdy
);
    logic             wr_en;
    logic             rd_en;
    logic [WIDTH-1:0] rd_word;

    sf_flags #(.DEPTH(DEPTH), .LAT(LAT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .shin    (shin),
        .shout   (shout),
        .in_rdy  (in_rdy),
        .out_rdy (out_rdy),
        .wr_en   (wr_en),
        .rd_en   (rd_en)
    );

    sf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .din     (din),
        .rd_word (rd_word)
    );

    // Drive the oldest word, or float the output when disabled.
    assign dout = oe ? rd_word : 'z;

    // R2
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (shin && in_rdy));
    // R10
    post_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !$past(shin)) |-> (in_rdy && !out_rdy));
endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
    localparam int W   = 4;
    localparam int D   = 64;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         oe = 1'b1;
    logic         shin = 1'b0;
    logic         shout = 1'b0;
    logic [W-1:0] din = '0;
    wire          in_rdy;
    wire          out_rdy;
    wire  [W-1:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    int q[$];
    int pend[$];
    int vis_m = 0;

    always #5 clk = ~clk;

    strobe_fifo #(.WIDTH(W), .DEPTH(D), .LAT(LAT)) i_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .oe(oe), .shin(shin), .din(din),
        .in_rdy(in_rdy), .shout(shout), .dout(dout), .out_rdy(out_rdy)
    );

    // Cascade pair for R12
    logic         c_shin = 1'b0;
    logic         c_shout = 1'b0;
    logic [W-1:0] c_din = '0;
    wire          a_ir, a_or, b_ir, b_or;
    wire  [W-1:0] a_dout, b_dout;

    strobe_fifo #(.WIDTH(W), .DEPTH(D), .LAT(LAT)) i_chain_a (
        .clk(clk), .rst_n(rst_n), .oe(1'b1), .shin(c_shin), .din(c_din),
        .in_rdy(a_ir), .shout(b_ir), .dout(a_dout), .out_rdy(a_or)
    );
    strobe_fifo #(.WIDTH(W), .DEPTH(D), .LAT(LAT)) i_chain_b (
        .clk(clk), .rst_n(rst_n), .oe(1'b1), .shin(a_or), .din(a_dout),
        .in_rdy(b_ir), .shout(c_shout), .dout(b_dout), .out_rdy(b_or)
    );

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FIFO FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare flags and the oldest word with the model.
    task automatic check_all;
        cmp("R1", int'(in_rdy), int'(q.size() < D));
        cmp("R5", int'(out_rdy), int'(vis_m > 0));
        if (oe && vis_m > 0) cmp("R3", int'(dout), q[0]);
    endtask

    // Drive one cycle, advance the model at the edge, check at the negedge.
    task automatic step(input bit s_in, input bit s_out, input int d);
        bit wr, rd;
        int inc;
        int keep[$];
        shin = s_in; shout = s_out; din = W'(d);
        @(posedge clk);
        if (!rst_n) begin
            q.delete(); pend.delete(); vis_m = 0;
        end else begin
            wr = s_in && (q.size() < D);
            rd = s_out && (vis_m > 0);
            inc = 0;
            foreach (pend[i]) begin
                if (pend[i] - 1 == 0) inc++;
                else keep.push_back(pend[i] - 1);
            end
            pend = keep;
            if (rd) void'(q.pop_front());
            if (wr) begin
                q.push_back(d & ((1 << W) - 1));
                if (LAT - 1 == 0) inc++;
                else pend.push_back(LAT - 1);
            end
            vis_m = vis_m + inc - int'(rd);
        end
        @(negedge clk);
        if (rst_n) check_all();
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        step(0, 0, 0);
        step(0, 0, 0);
        rst_n = 1'b1;
        // R10: empty after reset
        cmp("R10", int'(in_rdy), 1);
        cmp("R10", int'(out_rdy), 0);
    endtask

    task automatic drain;
        for (int k = 0; k < 4 * D && (q.size() > 0 || pend.size() > 0); k++)
            step(0, 1, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_cmp++; n_bad++;
                $display("FIFO FAIL watchdog: actual %0d expected below 150000", cycles);
                report();
            end
        end
    end

    initial begin
        int seed;
        int got;
        int sent;
        seed = $urandom(32'd4711);
        @(negedge clk);
        do_reset();

        // R6: bubble latency from an empty buffer
        step(1, 0, 9);
        cmp("R6", int'(out_rdy), int'(LAT - 1 <= 0));
        for (int k = 1; k <= LAT; k++) begin
            step(0, 0, 0);
            cmp("R6", int'(out_rdy), int'(k >= LAT - 1));
        end
        cmp("R3", int'(dout), 9);
        drain();

        // R2 / R3 / R4: a short burst, then reads one by one
        for (int k = 0; k < 5; k++) step(1, 0, k + 3);
        for (int k = 0; k < 5; k++) begin
            cmp("R4", int'(dout), k + 3);
            step(0, 1, 0);
        end
        cmp("R5", int'(out_rdy), 0);

        // R8: reads while empty, then a write must come out intact
        for (int k = 0; k < 3; k++) step(0, 1, 0);
        cmp("R8", int'(out_rdy), 0);
        step(1, 0, 6);
        step(0, 0, 0);
        step(0, 0, 0);
        cmp("R8", int'(dout), 6);
        drain();

        // R1 / R7: fill, push more while full, then drain in order
        for (int k = 0; k < D; k++) step(1, 0, k);
        cmp("R1", int'(in_rdy), 0);
        for (int k = 0; k < 3; k++) step(1, 0, 15);
        cmp("R7", int'(in_rdy), 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0);
        for (int k = 0; k < D; k++) begin
            cmp("R7", int'(dout), k % 16);
            step(0, 1, 0);
        end
        cmp("R1", int'(in_rdy), 1);

        // R9: both strobes at 63 words
        for (int k = 0; k < D - 1; k++) step(1, 0, k + 1);
        step(0, 0, 0);
        step(1, 1, 12);
        cmp("R9", int'(in_rdy), 1);
        step(1, 0, 13);
        cmp("R9", int'(in_rdy), 0);
        drain();

        // write into empty while shout is held
        step(1, 1, 2);
        step(0, 1, 0);
        step(0, 1, 0);
        cmp("R9", int'(out_rdy), 0);

        // R11: output disable floats dout, flags untouched
        step(1, 0, 10);
        step(0, 0, 0);
        step(0, 0, 0);
        oe = 1'b0;
        #1;
        n_cmp++;
        if (!(dout === 'z || dout == '0)) begin
            n_bad++;
            $display("FIFO FAIL R11: actual %0d expected high impedance", dout);
        end
        cmp("R11", int'(out_rdy), 1);
        cmp("R11", int'(in_rdy), 1);
        oe = 1'b1;
        #1;
        cmp("R11", int'(dout), 10);

        // R10: reset with data inside
        step(1, 0, 4);
        do_reset();

        // Random phase with swept fill bias
        for (int k = 0; k < 4000; k++) begin
            int bias;
            bias = ((k / 300) % 2 == 0) ? 70 : 30;
            step(($urandom % 100) < bias, ($urandom % 100) < (100 - bias),
                 int'($urandom % 16));
        end
        drain();

        // R12: cascade keeps order
        sent = 0;
        for (int k = 0; k < 400 && sent < 100; k++) begin
            c_shin = 1'b1;
            c_din = W'(sent * 7 + 1);
            @(posedge clk);
            if (a_ir) sent++;
            @(negedge clk);
        end
        c_shin = 1'b0;
        cmp("R12", sent, 100);
        got = 0;
        for (int k = 0; k < 1000 && got < 100; k++) begin
            c_shout = b_or;
            if (b_or) begin
                cmp("R12", int'(b_dout), (got * 7 + 1) % 16);
                got++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        c_shout = 1'b0;
        cmp("R12", got, 100);

        report();
    end
endmodule